// File: doc/BRIEF.md
# Operate Execution Unit with Condition Flags

This unit carries out the three arithmetic and logic operations of a small 16-bit instruction set: addition, bitwise AND and bitwise complement. It holds a bank of eight general-purpose registers and a three-bit condition register. Each cycle it may accept one instruction word, qualified by a valid strobe. In that same cycle it reads its operands, forms the result, writes the destination register and records the sign of the result.

An instruction whose opcode is not one of the three operate codes is dropped. It changes no register and no flag. A separate debug port lets a host or a test read any register one cycle after selecting it. The condition flags can be seen at all times.

Top module: `opx_exec_unit`

## Requirements
- R1: A synchronous active-high reset clears all eight registers to zero and sets the flags output to 3'b010. The flags bits are N in bit 2, Z in bit 1 and P in bit 0.
- R2: Opcode 4'b0001 in instr[15:12] with instr[5]=0 writes reg[instr[8:6]] + reg[instr[2:0]] to reg[instr[11:9]]. The sum wraps modulo 2^16.
- R3: With instr[5]=1, add and AND take their second operand from instr[4:0], sign-extended to 16 bits, so 5'b00101 is +5 and 5'b11110 is -2.
- R4: Opcode 4'b0101 writes the bitwise AND of the first source and the second operand. The second operand is a register or the immediate, chosen by instr[5].
- R5: Opcode 4'b1001 writes the bitwise complement of reg[instr[8:6]] to reg[instr[11:9]]. Bits [5:0] have no effect.
- R6: When a source and the destination are the same register, the result is computed from the values held before the write.
- R7: After every register write, exactly one flag is set, from the 16-bit two's complement result: N if it is negative, Z if it is zero, P if it is positive.
- R8: An instruction with any other opcode, or any cycle with instr_valid low, leaves all registers and the flags unchanged.
- R9: dbg_data shows, one cycle later, the register that dbg_sel selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr | input | 16 | Instruction word |
| dbg_sel | input | 3 | Register index for the debug read |
| dbg_data | output | 16 | Registered debug read data |
| flags | output | 3 | Condition flags {N,Z,P} |

## Verification
The bench goes after the immediate's sign bit by sweeping all 32 immediate values. A unit that zero-extends the immediate would turn -2 into +30. Sums are driven across 0x7FFF and 0xFFFF: a unit that saturates, or that takes the sign from a carry, ends up with the wrong value or the wrong flag. Every opcode outside the three operate codes, and a valid operate word with the strobe low, is applied and then all registers and flags are read back, to catch a unit that decodes only some opcode bits. Instructions whose destination is also a source expose a register bank that lets the new value reach its own operand.

// File: rtl/opx_pkg.sv
package opx_pkg;

  // Operate opcodes in instr[15:12]
  typedef enum logic [3:0] {
    OPC_ADD = 4'b0001,
    OPC_AND = 4'b0101,
    OPC_NOT = 4'b1001
  } opc_e;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_AND = 2'd1,
    ALU_NOT = 2'd2
  } alu_op_e;

  // Condition flags, N in bit 2, Z in bit 1, P in bit 0
  typedef struct packed {
    logic n;
    logic z;
    logic p;
  } cc_t;

  localparam cc_t CC_ZERO = '{n: 1'b0, z: 1'b1, p: 1'b0};

endpackage

// File: rtl/opx_decode.sv
module opx_decode
  import opx_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int INSTR_W = 16,
  parameter int IMM_W   = 5,
  parameter int SEL_W   = 3
) (
  input  logic [INSTR_W-1:0] instr,
  input  logic               instr_valid,
  output logic               wr_en,
  output logic [SEL_W-1:0]   dst,
  output logic [SEL_W-1:0]   src_a,
  output logic [SEL_W-1:0]   src_b,
  output logic               use_imm,
  output logic [DATA_W-1:0]  imm_ext,
  output alu_op_e            alu_op
);

  localparam int OPC_LSB = INSTR_W - 4;
  localparam int DST_LSB = OPC_LSB - SEL_W;
  localparam int SRA_LSB = DST_LSB - SEL_W;
  localparam int MODE_BIT = IMM_W;

  logic [3:0]       opc;
  logic [IMM_W-1:0] imm_raw;

  assign opc     = instr[INSTR_W-1:OPC_LSB];
  assign dst     = instr[DST_LSB +: SEL_W];
  assign src_a   = instr[SRA_LSB +: SEL_W];
  assign src_b   = instr[SEL_W-1:0];
  assign use_imm = instr[MODE_BIT];
  assign imm_raw = instr[IMM_W-1:0];
  assign imm_ext = {{(DATA_W-IMM_W){imm_raw[IMM_W-1]}}, imm_raw};

  always_comb begin
    wr_en  = 1'b0;
    alu_op = ALU_ADD;
    unique case (opc)
      OPC_ADD: begin wr_en = instr_valid; alu_op = ALU_ADD; end
      OPC_AND: begin wr_en = instr_valid; alu_op = ALU_AND; end
      OPC_NOT: begin wr_en = instr_valid; alu_op = ALU_NOT; end
      default: begin wr_en = 1'b0;        alu_op = ALU_ADD; end
    endcase
  end

endmodule

// File: rtl/opx_regfile.sv
module opx_regfile #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr_a,
  input  logic [AW-1:0]     raddr_b,
  output logic [DATA_W-1:0] rdata_a,
  output logic [DATA_W-1:0] rdata_b,
  input  logic [AW-1:0]     dbg_addr,
  output logic [DATA_W-1:0] dbg_rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  // Reads see the contents from before this edge's write
  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) dbg_rdata <= '0;
    else     dbg_rdata <= mem[dbg_addr];
  end

endmodule

// File: rtl/opx_alu.sv
module opx_alu
  import opx_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  output logic [DATA_W-1:0] result,
  output cc_t               cc
);

  always_comb begin
    unique case (op)
      ALU_ADD: result = opnd_a + opnd_b;
      ALU_AND: result = opnd_a & opnd_b;
      ALU_NOT: result = ~opnd_a;
      default: result = opnd_a + opnd_b;
    endcase
  end

  always_comb begin
    cc.n = result[DATA_W-1];
    cc.z = (result == '0);
    cc.p = !result[DATA_W-1] && (result != '0);
  end

endmodule

// File: rtl/opx_exec_unit.sv
module opx_exec_unit
  import opx_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IMM_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_valid,
  input  logic [15:0]       instr,
  input  logic [2:0]        dbg_sel,
  output logic [DATA_W-1:0] dbg_data,
  output logic [2:0]        flags
);

  localparam int INSTR_W = 16;
  localparam int SEL_W   = 3;
  localparam int REG_N   = 1 << SEL_W;

  logic              wr_en;
  logic [SEL_W-1:0]  dst, src_a, src_b;
  logic              use_imm;
  logic [DATA_W-1:0] imm_ext;
  alu_op_e           alu_op;
  logic [DATA_W-1:0] rd_a, rd_b, opnd_b, wr_data;
  cc_t               alu_cc, cc_q;

  opx_decode #(
    .DATA_W(DATA_W), .INSTR_W(INSTR_W), .IMM_W(IMM_W), .SEL_W(SEL_W)
  ) u_dec (
    .instr(instr), .instr_valid(instr_valid), .wr_en(wr_en),
    .dst(dst), .src_a(src_a), .src_b(src_b), .use_imm(use_imm),
    .imm_ext(imm_ext), .alu_op(alu_op)
  );

  opx_regfile #(
    .DATA_W(DATA_W), .DEPTH(REG_N), .AW(SEL_W)
  ) u_rf (
    .clk(clk), .rst(rst), .we(wr_en), .waddr(dst), .wdata(wr_data),
    .raddr_a(src_a), .raddr_b(src_b), .rdata_a(rd_a), .rdata_b(rd_b),
    .dbg_addr(dbg_sel), .dbg_rdata(dbg_data)
  );

  assign opnd_b = use_imm ? imm_ext : rd_b;

  opx_alu #(.DATA_W(DATA_W)) u_alu (
    .op(alu_op), .opnd_a(rd_a), .opnd_b(opnd_b), .result(wr_data), .cc(alu_cc)
  );

  always_ff @(posedge clk) begin
    if (rst)        cc_q <= CC_ZERO;
    else if (wr_en) cc_q <= alu_cc;
  end

  assign flags = cc_q;

endmodule

// File: rtl/opx_exec_chk.sv
module opx_exec_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              instr_valid,
  input logic [15:0]       instr,
  input logic [2:0]        flags,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data
);

  logic known_op;
  assign known_op = (instr[15:12] == 4'b0001) || (instr[15:12] == 4'b0101) ||
                    (instr[15:12] == 4'b1001);

  p_reset_z_r1: assert property (@(posedge clk) rst |=> flags == 3'b010);

  p_known_writes_r2: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && known_op) |-> wr_en);

  p_flags_onehot_r7: assert property (@(posedge clk) disable iff (rst)
    $countones(flags) == 1);

  p_flags_follow_r7: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> flags == {$past(wr_data[DATA_W-1]), $past(wr_data) == '0,
                        !$past(wr_data[DATA_W-1]) && $past(wr_data) != '0});

  p_foreign_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && !known_op) |=> $stable(flags));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !instr_valid |=> $stable(flags));

  p_no_write_r8: assert property (@(posedge clk) disable iff (rst)
    !(instr_valid && known_op) |-> !wr_en);

endmodule

bind opx_exec_unit opx_exec_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
  .flags(flags), .wr_en(wr_en), .wr_data(wr_data)
);

// File: tb/tb_opx_exec_unit.sv
`timescale 1ns/1ps
module tb_opx_exec_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic [15:0] instr = '0;
  logic [2:0]  dbg_sel = '0;
  logic [15:0] dbg_data;
  logic [2:0]  flags;

  int checks = 0;
  int errors = 0;
  logic [15:0] model [8];
  logic [2:0]  mflags;

  always #4 clk = ~clk;

  opx_exec_unit dut (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
    .dbg_sel(dbg_sel), .dbg_data(dbg_data), .flags(flags)
  );

  function automatic logic [15:0] sx5(input logic [4:0] v);
    return {{11{v[4]}}, v};
  endfunction

  function automatic logic [2:0] sign_of(input logic [15:0] r);
    if (r[15])        return 3'b100;
    else if (r == 0)  return 3'b010;
    else              return 3'b001;
  endfunction

  function automatic logic [15:0] e_add_r(input int d, input int a, input int b);
    return {4'b0001, 3'(d), 3'(a), 3'b000, 3'(b)};
  endfunction
  function automatic logic [15:0] e_add_i(input int d, input int a, input logic [4:0] k);
    return {4'b0001, 3'(d), 3'(a), 1'b1, k};
  endfunction
  function automatic logic [15:0] e_and_r(input int d, input int a, input int b);
    return {4'b0101, 3'(d), 3'(a), 3'b000, 3'(b)};
  endfunction
  function automatic logic [15:0] e_and_i(input int d, input int a, input logic [4:0] k);
    return {4'b0101, 3'(d), 3'(a), 1'b1, k};
  endfunction
  function automatic logic [15:0] e_not(input int d, input int a, input logic [5:0] low);
    return {4'b1001, 3'(d), 3'(a), low};
  endfunction

  // Reference behaviour from the requirements
  task automatic model_exec(input logic [15:0] w);
    logic [15:0] b, r;
    b = w[5] ? sx5(w[4:0]) : model[w[2:0]];
    case (w[15:12])
      4'b0001: r = model[w[8:6]] + b;
      4'b0101: r = model[w[8:6]] & b;
      4'b1001: r = ~model[w[8:6]];
      default: return;
    endcase
    model[w[11:9]] = r;
    mflags = sign_of(r);
  endtask

  task automatic chk16(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_flags(input string tag);
    checks++;
    if (flags !== mflags) begin
      errors++;
      $display("FAIL %s flags actual=%b expected=%b", tag, flags, mflags);
    end
  endtask

  // One instruction; flags checked one cycle later
  task automatic run(input logic [15:0] w, input string tag);
    @(negedge clk);
    instr = w;
    instr_valid = 1'b1;
    model_exec(w);
    @(negedge clk);
    instr_valid = 1'b0;
    chk_flags(tag);
  endtask

  task automatic chk_reg(input int r, input string tag);
    @(negedge clk);
    dbg_sel = 3'(r);
    @(negedge clk);
    chk16(tag, dbg_data, model[r]);
  endtask

  task automatic chk_all(input string tag);
    for (int r = 0; r < 8; r++) chk_reg(r, tag);
  endtask

  // Build any 16-bit value by doubling and adding one
  task automatic load(input int r, input logic [15:0] v);
    run(e_and_i(r, r, 5'd0), "R4 load clear");
    for (int i = 15; i >= 0; i--) begin
      run(e_add_r(r, r, r), "R6 load double");
      if (v[i]) run(e_add_i(r, r, 5'd1), "R3 load inc");
    end
  endtask

  localparam logic [15:0] PAT [6] = '{16'h0000, 16'h0001, 16'h7FFF,
                                      16'h8000, 16'hFFFF, 16'h5A3C};

  initial begin
    for (int i = 0; i < 8; i++) model[i] = '0;
    mflags = 3'b010;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk_flags("R1 reset flags");
    chk_all("R1 reset registers");

    // R3: every immediate value, added to zero and to 0x7FFF
    for (int k = 0; k < 32; k++) begin
      run(e_add_i(1, 0, 5'(k)), "R3 imm flags");
      chk_reg(1, "R3 imm from zero");
      chk16("R3 sign extension", model[1], sx5(5'(k)));
    end
    load(2, 16'h7FFF);
    chk_reg(2, "R2 load 7fff");
    for (int k = 0; k < 32; k += 3) begin
      run(e_add_i(3, 2, 5'(k)), "R7 wrap flags");
      chk_reg(3, "R3 imm add 7fff");
    end

    // R2/R4/R5 over register pairs
    for (int i = 0; i < 6; i++) begin
      load(4, PAT[i]);
      for (int j = 0; j < 6; j++) begin
        load(5, PAT[j]);
        run(e_add_r(6, 4, 5), "R7 add flags");
        chk_reg(6, "R2 add register");
        chk16("R2 wrap", model[6], 16'(PAT[i] + PAT[j]));
        run(e_and_r(7, 4, 5), "R7 and flags");
        chk_reg(7, "R4 and register");
      end
      run(e_and_i(6, 4, 5'b11110), "R7 and imm flags");
      chk_reg(6, "R4 and immediate");
      run(e_not(7, 4, 6'(i * 11)), "R7 not flags");
      chk_reg(7, "R5 not");
      chk16("R5 not value", model[7], ~PAT[i]);
    end

    // R6: destination equal to source
    load(2, 16'h4001);
    run(e_add_r(2, 2, 2), "R6 flags");
    chk_reg(2, "R6 add self");
    chk16("R6 add self value", model[2], 16'h8002);
    run(e_not(2, 2, 6'h3F), "R6 not flags");
    chk_reg(2, "R6 not self");
    run(e_and_r(2, 2, 2), "R6 and flags");
    chk_reg(2, "R6 and self");

    // R8: foreign opcodes and idle cycles change nothing
    load(1, 16'h8000);
    for (int op = 0; op < 16; op++) begin
      if (op == 1 || op == 5 || op == 9) continue;
      run({4'(op), 12'hFFF ^ 12'(op * 37)}, "R8 foreign flags");
    end
    chk_all("R8 foreign registers");
    @(negedge clk);
    instr = e_add_i(1, 1, 5'd1);
    instr_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk_flags("R8 idle flags");
    chk_all("R8 idle registers");

    // R9: debug port alternates selections
    for (int r = 7; r >= 0; r--) chk_reg(r, "R9 debug select");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule